// File: doc/BRIEF.md
# Prioritized Interruption Status-Word Swapper

This block sits beside a processor's control unit and owns the 64-bit current status word. Five interruption classes (machine check, program, supervisor call, external, I/O) raise requests with per-class codes. The block latches these requests and filters them through the enable bits held in the current word. When a request is eligible, the block picks one by fixed priority and performs a context switch through memory. It first writes the outgoing word, with the interruption code and instruction length inserted, to the class's old-word doubleword. It then reads the class's new-word doubleword and installs it as the current word.

Bit numbering follows the convention in which status-word bit 0 is the most significant, so bit n is `psw[63-n]`. The control FSM has three states. S_IDLE arbitrates and accepts host loads. S_STORE_OLD holds a write request until ready. S_FETCH_NEW holds a read request until ready. The transitions are IDLE→STORE_OLD when an eligible request exists and no host load is present, STORE_OLD→FETCH_NEW on write ready, and FETCH_NEW→IDLE on read ready, when the word is installed. A halted (wait bit set) processor is resumed by an ordinary swap.

Top module: `psw_swapper`

## Requirements
- R1: After reset the current word is zero, no request is pending and `mem_req` is low.
- R2: Enables are taken from the current word: machine check is enabled by bit 13, external by bit 7, I/O channel c (0..5) by bit c, and channel 6 (all remaining channels) by bit 6. Program and supervisor-call requests are never masked.
- R3: A masked machine-check, external or I/O request stays pending and is serviced as soon as the current word enables it.
- R4: A program request with code 0 is discarded. Codes 8, 10, 13 and 14 are discarded when bit 36, 37, 38 or 39 respectively is 0. A discarded request is never serviced later.
- R5: Priority among eligible requests runs machine check, then program, then supervisor call, then external, then I/O. Among I/O channels the lowest channel number wins. The losers remain pending.
- R6: The old/new doubleword addresses are: external 0x18/0x58, supervisor call 0x20/0x60, program 0x28/0x68, machine check 0x30/0x70, I/O 0x38/0x78.
- R7: A swap first writes the old word, which is the current word with bits 16-31 replaced by the code and bits 32-33 replaced by the instruction length, all other bits unchanged. It then reads the new word at old address + 0x40.
- R8: The read data are installed as the current word on the read handshake. Only one swap is in flight, and pending requests are arbitrated again only after the install.
- R9: Codes: machine check uses its 16-bit input code. Program uses its 4-bit code, zero-extended. Supervisor call uses its 8-bit immediate, zero-extended. External uses 8 zero bits followed by the pending flags (timer at bit 24, interrupt key at bit 25, signals 2-7 at bits 26-31), and all reported flags are cleared. I/O uses the channel number in bits 16-23 and the latched device address in bits 24-31. The length is the supplied value for program and supervisor call and 0 for other classes.
- R10: With the wait bit (14) set, an enabled request still swaps. The stored old word keeps the wait bit, and the installed word decides whether the processor stays halted.
- R11: A host load (`psw_wr`) replaces the current word in S_IDLE and takes precedence over starting a swap in that cycle. It is ignored while a swap is in flight.
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready` is seen at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mck_req | input | 1 | Machine-check request pulse |
| mck_code | input | 16 | Machine-check code |
| pgm_req | input | 1 | Program exception pulse |
| pgm_code | input | 4 | Program exception code 1..15 |
| pgm_ilc | input | 2 | Instruction length of the failing instruction |
| svc_req | input | 1 | Supervisor-call pulse |
| svc_imm | input | 8 | Supervisor-call immediate |
| svc_ilc | input | 2 | Supervisor-call instruction length |
| ext_req | input | 8 | External event pulses; [7] timer, [6] key, [5:0] signals 2..7 |
| io_req | input | 7 | Per-channel I/O completion pulse |
| io_dev | input | 56 | Device address per channel, channel c in [8c+7:8c] |
| psw_wr | input | 1 | Host load of the current word |
| psw_wdata | input | 64 | Word to load |
| psw | output | 64 | Current status word |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write old word, 0 = read new word |
| mem_addr | output | 24 | Doubleword byte address |
| mem_wdata | output | 64 | Old word being stored |
| mem_rdata | input | 64 | New word read back |
| mem_ready | input | 1 | Memory completes the request at this edge |

## Verification
The main stimulus is a burst in which all five classes fire in the same cycle. This separates the priority order and shows that masked classes wait for a later host load. Randomized rounds then pair a random status word with one event of a random class. This separates enabled and masked outcomes, tests code and length insertion over random filler bits, and tests address selection. Directed cases cover the program mask codes, two I/O channels raised together, a swap out of the wait state, a host load issued during a swap, and memory ready with random latency.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;

    typedef enum logic [2:0] {
        CL_EXT = 3'd0,
        CL_SVC = 3'd1,
        CL_PGM = 3'd2,
        CL_MCK = 3'd3,
        CL_IO  = 3'd4
    } irq_class_e;

    localparam logic [7:0] NEW_SLOT_OFFSET = 8'h40;

    // Old-word doubleword per class; the new word sits NEW_SLOT_OFFSET higher.
    function automatic logic [7:0] old_slot(irq_class_e c);
        logic [7:0] a;
        unique case (c)
            CL_EXT:  a = 8'h18;
            CL_SVC:  a = 8'h20;
            CL_PGM:  a = 8'h28;
            CL_MCK:  a = 8'h30;
            default: a = 8'h38;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/psw_irq_pending.sv
module psw_irq_pending
    import psw_swap_pkg::*;
#(
    parameter int NUM_IO_CH = 7,
    parameter int DEV_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 sys_mask,
    input  logic                       mck_en,
    input  logic [3:0]                 pgm_mask,
    input  logic                       take,
    input  logic                       mck_req,
    input  logic [15:0]                mck_code,
    input  logic                       pgm_req,
    input  logic [3:0]                 pgm_code,
    input  logic [1:0]                 pgm_ilc,
    input  logic                       svc_req,
    input  logic [7:0]                 svc_imm,
    input  logic [1:0]                 svc_ilc,
    input  logic [7:0]                 ext_req,
    input  logic [NUM_IO_CH-1:0]       io_req,
    input  logic [NUM_IO_CH*DEV_W-1:0] io_dev,
    output logic                       win_vld,
    output irq_class_e                 win_class,
    output logic [15:0]                win_code,
    output logic [1:0]                 win_ilc
);
    localparam int DIRECT_CH = 6;
    localparam int CH_W      = 16 - DEV_W;
    localparam int SEL_W     = (NUM_IO_CH > 1) ? $clog2(NUM_IO_CH) : 1;

    logic                 mck_pend, pgm_pend, svc_pend;
    logic [15:0]          mck_code_q;
    logic [3:0]           pgm_code_q;
    logic [1:0]           pgm_ilc_q, svc_ilc_q;
    logic [7:0]           svc_imm_q;
    logic [7:0]           ext_pend;
    logic [NUM_IO_CH-1:0] io_pend, io_en, io_hit;
    logic [DEV_W-1:0]     dev_q [NUM_IO_CH];
    logic [SEL_W-1:0]     sel_ch;
    logic                 pgm_drop;
    logic                 ext_en;

    assign ext_en = sys_mask[0];

    // Channel enables: low channels have their own bit, the rest share bit 6.
    for (genvar c = 0; c < NUM_IO_CH; c++) begin : g_io_en
        if (c < DIRECT_CH) begin : g_direct
            assign io_en[c] = sys_mask[7-c];
        end else begin : g_shared
            assign io_en[c] = sys_mask[1];
        end
    end
    assign io_hit = io_pend & io_en;

    always_comb begin
        unique case (pgm_code)
            4'd0:    pgm_drop = 1'b1;
            4'd8:    pgm_drop = !pgm_mask[3];
            4'd10:   pgm_drop = !pgm_mask[2];
            4'd13:   pgm_drop = !pgm_mask[1];
            4'd14:   pgm_drop = !pgm_mask[0];
            default: pgm_drop = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mck_pend   <= 1'b0;
            pgm_pend   <= 1'b0;
            svc_pend   <= 1'b0;
            ext_pend   <= '0;
            io_pend    <= '0;
            mck_code_q <= '0;
            pgm_code_q <= '0;
            pgm_ilc_q  <= '0;
            svc_imm_q  <= '0;
            svc_ilc_q  <= '0;
        end else begin
            mck_pend <= (mck_pend && !(take && win_class == CL_MCK)) || mck_req;
            pgm_pend <= (pgm_pend && !(take && win_class == CL_PGM)) || (pgm_req && !pgm_drop);
            svc_pend <= (svc_pend && !(take && win_class == CL_SVC)) || svc_req;
            ext_pend <= ((take && win_class == CL_EXT) ? 8'h00 : ext_pend) | ext_req;
            if (mck_req) mck_code_q <= mck_code;
            if (pgm_req && !pgm_drop) begin
                pgm_code_q <= pgm_code;
                pgm_ilc_q  <= pgm_ilc;
            end
            if (svc_req) begin
                svc_imm_q <= svc_imm;
                svc_ilc_q <= svc_ilc;
            end
            for (int c = 0; c < NUM_IO_CH; c++) begin
                io_pend[c] <= (io_pend[c] && !(take && win_class == CL_IO && sel_ch == SEL_W'(c)))
                              || io_req[c];
            end
        end
    end

    for (genvar c = 0; c < NUM_IO_CH; c++) begin : g_dev
        always_ff @(posedge clk) begin
            if (!rst_n)         dev_q[c] <= '0;
            else if (io_req[c]) dev_q[c] <= io_dev[c*DEV_W +: DEV_W];
        end
    end

    always_comb begin
        sel_ch = '0;
        for (int c = NUM_IO_CH - 1; c >= 0; c--) begin
            if (io_hit[c]) sel_ch = SEL_W'(c);
        end
    end

    always_comb begin
        win_vld   = 1'b1;
        win_class = CL_EXT;
        win_code  = '0;
        win_ilc   = 2'b00;
        if (mck_pend && mck_en) begin
            win_class = CL_MCK;
            win_code  = mck_code_q;
        end else if (pgm_pend) begin
            win_class = CL_PGM;
            win_code  = {12'h000, pgm_code_q};
            win_ilc   = pgm_ilc_q;
        end else if (svc_pend) begin
            win_class = CL_SVC;
            win_code  = {8'h00, svc_imm_q};
            win_ilc   = svc_ilc_q;
        end else if (ext_pend != 8'h00 && ext_en) begin
            win_class = CL_EXT;
            win_code  = {8'h00, ext_pend};
        end else if (io_hit != '0) begin
            win_class = CL_IO;
            win_code  = {CH_W'(sel_ch), dev_q[sel_ch]};
        end else begin
            win_vld   = 1'b0;
        end
    end

    // R3: masked external flags are never lost
    a_r3_ext_kept_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en) |=> ((ext_pend & $past(ext_pend)) == $past(ext_pend)));

    // R3: masked machine check remains pending
    a_r3_mck_kept_while_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_pend && !mck_en) |=> mck_pend);

    // R4: a masked fixed-point overflow never becomes pending
    a_r4_masked_pgm_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && pgm_code == 4'd8 && !pgm_mask[3] && !pgm_pend) |=> !pgm_pend);

    // R5: a taken I/O channel is never outranked by an enabled lower channel
    a_r5_lowest_channel: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_class == CL_IO && io_hit[0]) |-> (win_code[15:DEV_W] == '0));

endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
    import psw_swap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_vld,
    input  irq_class_e        win_class,
    input  logic [15:0]       win_code,
    input  logic [1:0]        win_ilc,
    input  logic              psw_wr,
    input  logic [63:0]       psw_wdata,
    output logic              take,
    output logic [63:0]       psw_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ready
);
    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_STORE_OLD = 2'd1,
        S_FETCH_NEW = 2'd2
    } state_e;

    state_e     state, state_nx;
    irq_class_e cls_q;
    logic [63:0] old_word_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (!psw_wr && win_vld) state_nx = S_STORE_OLD;
            S_STORE_OLD: if (mem_ready)          state_nx = S_FETCH_NEW;
            S_FETCH_NEW: if (mem_ready)          state_nx = S_IDLE;
            default:                             state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        take      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = old_word_q;
        unique case (state)
            S_IDLE:      take = !psw_wr && win_vld;
            S_STORE_OLD: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = ADDR_W'(old_slot(cls_q));
            end
            S_FETCH_NEW: begin
                mem_req  = 1'b1;
                mem_addr = ADDR_W'(old_slot(cls_q) + NEW_SLOT_OFFSET);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw_q      <= '0;
            cls_q      <= CL_EXT;
            old_word_q <= '0;
        end else begin
            if (state == S_IDLE && psw_wr) psw_q <= psw_wdata;
            if (take) begin
                cls_q      <= win_class;
                old_word_q <= {psw_q[63:48], win_code, win_ilc, psw_q[29:0]};
            end
            if (state == S_FETCH_NEW && mem_ready) psw_q <= mem_rdata;
        end
    end

    // R12: request fields hold until accepted
    a_r12_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                      && $stable(mem_wdata)));

    // R7: the read of the new word follows the write, 0x40 higher
    a_r7_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=> (mem_req && !mem_we
                                               && mem_addr == $past(mem_addr) + ADDR_W'(8'h40)));

    // R8: the read data become the current word and the port goes idle
    a_r8_install: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (!mem_req && psw_q == $past(mem_rdata)));

    // R11: the current word is frozen during a swap
    a_r11_frozen_in_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !(!mem_we && mem_ready)) |=> $stable(psw_q));

    // R6: every access hits a doubleword inside the slot area
    a_r6_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000 && mem_addr >= ADDR_W'(8'h18)
                     && mem_addr <= ADDR_W'(8'h78)));

endmodule

// File: rtl/psw_swapper.sv
module psw_swapper
    import psw_swap_pkg::*;
#(
    parameter int NUM_IO_CH = 7,
    parameter int DEV_W     = 8,
    parameter int ADDR_W    = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mck_req,
    input  logic [15:0]                mck_code,
    input  logic                       pgm_req,
    input  logic [3:0]                 pgm_code,
    input  logic [1:0]                 pgm_ilc,
    input  logic                       svc_req,
    input  logic [7:0]                 svc_imm,
    input  logic [1:0]                 svc_ilc,
    input  logic [7:0]                 ext_req,
    input  logic [NUM_IO_CH-1:0]       io_req,
    input  logic [NUM_IO_CH*DEV_W-1:0] io_dev,
    input  logic                       psw_wr,
    input  logic [63:0]                psw_wdata,
    output logic [63:0]                psw,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [63:0]                mem_wdata,
    input  logic [63:0]                mem_rdata,
    input  logic                       mem_ready
);
    logic        take, win_vld;
    irq_class_e  win_class;
    logic [15:0] win_code;
    logic [1:0]  win_ilc;

    psw_irq_pending #(.NUM_IO_CH(NUM_IO_CH), .DEV_W(DEV_W)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_mask  (psw[63:56]),
        .mck_en    (psw[50]),
        .pgm_mask  (psw[27:24]),
        .take      (take),
        .mck_req   (mck_req),
        .mck_code  (mck_code),
        .pgm_req   (pgm_req),
        .pgm_code  (pgm_code),
        .pgm_ilc   (pgm_ilc),
        .svc_req   (svc_req),
        .svc_imm   (svc_imm),
        .svc_ilc   (svc_ilc),
        .ext_req   (ext_req),
        .io_req    (io_req),
        .io_dev    (io_dev),
        .win_vld   (win_vld),
        .win_class (win_class),
        .win_code  (win_code),
        .win_ilc   (win_ilc)
    );

    psw_swap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_vld   (win_vld),
        .win_class (win_class),
        .win_code  (win_code),
        .win_ilc   (win_ilc),
        .psw_wr    (psw_wr),
        .psw_wdata (psw_wdata),
        .take      (take),
        .psw_q     (psw),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

endmodule

// File: tb/psw_swapper_bench.sv
`timescale 1ns/1ps
module psw_swapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mck_req = 0, pgm_req = 0, svc_req = 0, psw_wr = 0;
    logic [15:0] mck_code = 0;
    logic [3:0]  pgm_code = 0;
    logic [1:0]  pgm_ilc = 0, svc_ilc = 0;
    logic [7:0]  svc_imm = 0, ext_req = 0;
    logic [6:0]  io_req = 0;
    logic [55:0] io_dev = 0;
    logic [63:0] psw_wdata = 0, psw, mem_wdata, mem_rdata;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [23:0] mem_addr;

    logic [63:0] mem [16];
    int n_chk = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0, wr_seen = 0, cyc = 0;
    logic [23:0] wr_addr_q;
    logic [63:0] wr_data_q;
    logic [63:0] cur;

    always #10 clk = ~clk;

    psw_swapper u_psw_swapper (
        .clk(clk), .rst_n(rst_n), .mck_req(mck_req), .mck_code(mck_code),
        .pgm_req(pgm_req), .pgm_code(pgm_code), .pgm_ilc(pgm_ilc),
        .svc_req(svc_req), .svc_imm(svc_imm), .svc_ilc(svc_ilc),
        .ext_req(ext_req), .io_req(io_req), .io_dev(io_dev),
        .psw_wr(psw_wr), .psw_wdata(psw_wdata), .psw(psw),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

    assign mem_rdata = mem[mem_addr[6:3]];

    always @(negedge clk) mem_ready <= mem_req && ($urandom_range(0, 2) != 0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready && mem_we) begin
            wr_addr_q <= mem_addr;
            wr_data_q <= mem_wdata;
            wr_cnt    <= wr_cnt + 1;
        end
        if (mem_req && mem_ready && !mem_we) rd_cnt <= rd_cnt + 1;
    end

    function automatic logic [63:0] new_word(int slot);
        return {40'h0, 24'h0A0000 | 24'(slot << 4)};
    endfunction

    function automatic logic [63:0] ins(logic [63:0] p, logic [15:0] code, logic [1:0] ilc);
        return {p[63:48], code, ilc, p[29:0]};
    endfunction

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic set_psw(logic [63:0] v);
        @(negedge clk);
        psw_wr = 1'b1; psw_wdata = v;
        @(negedge clk);
        psw_wr = 1'b0;
        cur = v;
        check64("R11 host load", psw, v);
    endtask

    task automatic expect_swap(string req, logic [7:0] old_a, logic [15:0] code, logic [1:0] ilc);
        int t = 0;
        logic [63:0] exp_old = ins(cur, code, ilc);
        int rd0;
        while (wr_cnt == wr_seen && t < 200) begin @(negedge clk); t++; end
        wr_seen = wr_cnt;
        rd0 = rd_cnt;
        check64({req, " old address"}, 64'(wr_addr_q), 64'(old_a));
        check64({req, " old word"}, wr_data_q, exp_old);
        t = 0;
        while (rd_cnt == rd0 && t < 200) begin @(negedge clk); t++; end
        cur = new_word((int'(old_a) + 'h40) >> 3);
        check64({req, " R8 installed word"}, psw, cur);
    endtask

    task automatic expect_none(string req, int cycles);
        int w0 = wr_cnt;
        repeat (cycles) @(negedge clk);
        check64({req, " no swap"}, 64'(wr_cnt - w0), 64'd0);
    endtask

    task automatic pulse(int cls, logic [15:0] a, logic [7:0] b, logic [1:0] ilc);
        @(negedge clk);
        case (cls)
            0: begin mck_req = 1; mck_code = a; end
            1: begin pgm_req = 1; pgm_code = a[3:0]; pgm_ilc = ilc; end
            2: begin svc_req = 1; svc_imm = a[7:0]; svc_ilc = ilc; end
            3: ext_req = a[7:0];
            default: begin io_req[a[2:0]] = 1'b1; io_dev[a[2:0]*8 +: 8] = b; end
        endcase
        @(negedge clk);
        mck_req = 0; pgm_req = 0; svc_req = 0; ext_req = 0; io_req = 0;
    endtask

    function automatic logic pgm_dropped(logic [3:0] c, logic [63:0] p);
        case (c)
            4'd0:  return 1'b1;
            4'd8:  return !p[27];
            4'd10: return !p[26];
            4'd13: return !p[25];
            4'd14: return !p[24];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        while (cyc < 150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
    end

    localparam logic [63:0] P_ALL = (64'h1 << 50) | (64'h1 << 56) | (64'h1 << 61) | 64'h100;

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 16; i++) mem[i] = new_word(i);
        repeat (3) @(negedge clk);
        // R1: reset state
        check64("R1 reset word", psw, 64'h0);
        check64("R1 reset request", 64'(mem_req), 64'h0);
        rst_n = 1'b1;
        expect_none("R1 idle after reset", 6);

        // R5, R6, R9: every class at once
        set_psw(P_ALL);
        @(negedge clk);
        mck_req = 1; mck_code = 16'hBEEF;
        pgm_req = 1; pgm_code = 4'd1; pgm_ilc = 2'd2;
        svc_req = 1; svc_imm = 8'h2A; svc_ilc = 2'd1;
        ext_req = 8'h80; io_req[2] = 1'b1; io_dev[23:16] = 8'h33;
        @(negedge clk);
        mck_req = 0; pgm_req = 0; svc_req = 0; ext_req = 0; io_req = 0;
        expect_swap("R5 machine check first", 8'h30, 16'hBEEF, 2'd0);
        expect_swap("R5 program second", 8'h28, 16'h0001, 2'd2);
        expect_swap("R5 supervisor call third", 8'h20, 16'h002A, 2'd1);
        expect_none("R3 external and I/O held", 20);
        set_psw(P_ALL);
        expect_swap("R9 external timer code", 8'h18, 16'h0080, 2'd0);
        expect_none("R3 I/O held", 12);
        set_psw(P_ALL);
        expect_swap("R9 I/O channel code", 8'h38, 16'h0233, 2'd0);

        // R4: program mask handling
        set_psw(64'h200);
        pulse(1, 16'd8, 8'h0, 2'd2);
        pulse(1, 16'd14, 8'h0, 2'd2);
        pulse(1, 16'd0, 8'h0, 2'd2);
        expect_none("R4 masked codes", 10);
        set_psw(64'h200 | (64'h1 << 27) | (64'h1 << 24));
        expect_none("R4 discarded stays gone", 10);
        pulse(1, 16'd8, 8'h0, 2'd3);
        expect_swap("R4 enabled overflow", 8'h28, 16'h0008, 2'd3);

        // R5: lowest I/O channel wins
        set_psw((64'h1 << 62) | (64'h1 << 59));
        @(negedge clk);
        io_req = 7'b0010010; io_dev[15:8] = 8'h11; io_dev[39:32] = 8'h44;
        @(negedge clk);
        io_req = 0;
        expect_swap("R5 channel 1 first", 8'h38, 16'h0111, 2'd0);
        set_psw((64'h1 << 59));
        expect_swap("R2 channel 4 next", 8'h38, 16'h0444, 2'd0);

        // R10: wake from wait
        set_psw((64'h1 << 49) | (64'h1 << 56) | 64'h400);
        pulse(3, 16'h0001, 8'h0, 2'd0);
        expect_swap("R10 swap from wait", 8'h18, 16'h0001, 2'd0);
        check64("R10 wait cleared by new word", 64'(psw[49]), 64'd0);

        // R11: host load ignored during a swap
        set_psw(64'h500);
        pulse(2, 16'h0077, 8'h0, 2'd2);
        while (!mem_req) @(negedge clk);
        psw_wr = 1'b1; psw_wdata = 64'hDEAD_BEEF_0000_0000;
        @(negedge clk);
        psw_wr = 1'b0;
        expect_swap("R11 load ignored in swap", 8'h20, 16'h0077, 2'd2);

        // Randomized rounds
        for (int it = 0; it < 40; it++) begin
            logic [63:0] p;
            int cls, ch;
            logic [15:0] a;
            logic [7:0] b;
            logic [1:0] ilc;
            logic en;
            logic [63:0] en_bit;
            logic [15:0] code;
            logic [7:0] slot;
            p = {$urandom(), $urandom()};
            cls = $urandom_range(0, 4);
            a = 16'($urandom());
            b = 8'($urandom());
            ilc = 2'($urandom());
            ch = $urandom_range(0, 6);
            en_bit = 0;
            case (cls)
                0: begin en = p[50]; en_bit = 64'h1 << 50; code = a; slot = 8'h30; ilc = ilc; end
                1: begin a = {12'h0, a[3:0]}; en = !pgm_dropped(a[3:0], p); code = a; slot = 8'h28; end
                2: begin a = {8'h0, a[7:0]}; en = 1'b1; code = a; slot = 8'h20; end
                3: begin a = {8'h0, a[7:0] | 8'h01}; en = p[56]; en_bit = 64'h1 << 56; code = a; slot = 8'h18; end
                default: begin
                    a = 16'(ch);
                    en = (ch < 6) ? p[63-ch] : p[57];
                    en_bit = (ch < 6) ? (64'h1 << (63 - ch)) : (64'h1 << 57);
                    code = {8'(ch), b}; slot = 8'h38;
                end
            endcase
            set_psw(p);
            pulse(cls, a, b, ilc);
            if (cls != 1 && cls != 2) ilc = 2'd0;
            if (en) begin
                expect_swap("R7 random swap", slot, code, ilc);
            end else begin
                expect_none("R2 random masked", 12);
                if (cls != 1) begin
                    set_psw(p | en_bit);
                    expect_swap("R3 random released", slot, code, ilc);
                end
            end
        end
        finish_run();
    end
endmodule